// File: doc/BRIEF.md
# Serial Register Programming Interface

This block is a three-wire serial loader for a frequency synthesizer's setting registers. A host shifts 24-bit words in on a serial data line, one bit per rising edge of a serial clock, with the most significant bit first. A rising edge on a load strobe then copies the word into one of four holding registers. The two lowest bits of the word select which one. The serial clock, data and load strobe are taken into the system clock domain through two-stage synchronizers. Edges are found on the synchronized copies, so every register in the block runs on one clock.

The holding registers drive parallel outputs: the reference divider value, the integer and fractional parts of the feedback divider, the modulus, the raw control word, the raw noise/spur word, and a 3-bit select for the status output multiplexer. The modulus is buffered in two stages. A reference-register write only stages the new value. The value becomes active at the next feedback-register write. A one-cycle strobe marks each register that was written, and a separate strobe marks a change in the active modulus.

Top module: `serial_reg_loader`

## Requirements
- R1: After reset, every parallel output is zero, `mux_sel` is 000 (the three-state code), and no strobe is high.
- R2: Each rising edge of `ser_clk` shifts `ser_data` into bit 0 of a 24-bit shift register, moving the older bits toward bit 23, so the data arrives MSB first. A load always uses the last 24 bits shifted, whatever number of bits came since the previous load; the shift register is never cleared.
- R3: A load with word bits [1:0] = 00 writes the feedback register: `frac` takes bits [13:2] and `n_int` takes bits [22:14].
- R4: A load with bits [1:0] = 01 writes the reference register: `r_div` takes bits [17:14], and bits [13:2] go to the modulus staging register. `mod_active` does not change.
- R5: A load with bits [1:0] = 10 writes the control register: `ctrl_word` takes the whole word, and `mux_sel` takes bits [4:2].
- R6: A load with bits [1:0] = 11 writes the noise/spur register: `spur_word` takes the whole word.
- R7: A load changes only the outputs that belong to the addressed register.
- R8: A feedback-register load copies the staged modulus to `mod_active`. `mod_stb` pulses for one cycle only when this copy changes `mod_active`. Nothing else changes `mod_active`.
- R9: Each load produces exactly one one-cycle pulse on `upd_stb`, on the bit whose index equals the address code (bit 0 feedback, 1 reference, 2 control, 3 noise/spur).
- R10: Shifting bits without a rising edge of `ser_le` changes no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial shift clock (asynchronous) |
| ser_data | input | 1 | Serial data, MSB first (asynchronous) |
| ser_le | input | 1 | Load strobe, acts on its rising edge (asynchronous) |
| r_div | output | 4 | Reference divider value |
| n_int | output | 9 | Integer feedback divider value |
| frac | output | 12 | Fractional feedback value |
| mod_active | output | 12 | Active modulus |
| ctrl_word | output | 24 | Raw control register |
| spur_word | output | 24 | Raw noise/spur register |
| mux_sel | output | 3 | Status multiplexer select |
| upd_stb | output | 4 | One-cycle write strobe per holding register |
| mod_stb | output | 1 | One-cycle strobe when the active modulus changes |

## Verification
The hardest case to reach is the modulus hand-off. A staged value must stay hidden through any number of control and noise/spur loads. It must then appear only at the next feedback load, with `mod_stb` firing only if the value really changed. Random sequences mix all four addresses, so reference loads are often separated from the next feedback load by other writes. Directed steps repeat a feedback load with an unchanged staged value to show that the strobe stays low. Other steps send bursts longer or shorter than 24 bits to exercise the rule that the last 24 bits are used.

// File: rtl/srl_pkg.sv
package srl_pkg;
  localparam int WORD_W   = 24;
  localparam int ADDR_W   = 2;
  localparam int N_REGS   = 1 << ADDR_W;
  localparam int SYNC_N   = 2;

  localparam int FRAC_LSB = 2;
  localparam int FRAC_W   = 12;
  localparam int NINT_LSB = 14;
  localparam int NINT_W   = 9;
  localparam int MOD_LSB  = 2;
  localparam int MOD_W    = 12;
  localparam int RDIV_LSB = 14;
  localparam int RDIV_W   = 4;
  localparam int MUX_LSB  = 2;
  localparam int MUX_W    = 3;

  typedef enum logic [ADDR_W-1:0] {
    ADR_FB   = 2'd0,
    ADR_REF  = 2'd1,
    ADR_CTRL = 2'd2,
    ADR_SPUR = 2'd3
  } reg_addr_e;

  typedef enum logic [MUX_W-1:0] {
    MUX_HIZ   = 3'd0,
    MUX_DLOCK = 3'd1,
    MUX_NOUT  = 3'd2,
    MUX_HIGH  = 3'd3,
    MUX_ROUT  = 3'd4,
    MUX_ALOCK = 3'd5,
    MUX_FLOCK = 3'd6,
    MUX_LOW   = 3'd7
  } mux_code_e;
endpackage

// File: rtl/srl_sync.sv
module srl_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= '0;
    else     chain[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[s] <= '0;
      else     chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/srl_edge.sv
module srl_edge #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] sig,
  output logic [W-1:0] rise
);
  logic [W-1:0] prev;

  always_ff @(posedge clk) begin
    if (rst) prev <= '0;
    else     prev <= sig;
  end

  for (genvar i = 0; i < W; i++) begin : g_rise
    assign rise[i] = sig[i] & ~prev[i];
  end
endmodule

// File: rtl/srl_shifter.sv
module srl_shifter
  import srl_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_en,
  input  logic              bit_in,
  output logic [WORD_W-1:0] word
);
  always_ff @(posedge clk) begin
    if (rst)           word <= '0;
    else if (shift_en) word <= {word[WORD_W-2:0], bit_in};
  end

  // R2: the newest bit lands in bit 0, older bits move up one place
  a_r2_msb_first_shift: assert property (@(posedge clk) disable iff (rst)
    $past(shift_en) && !$past(rst) |->
      (word[0] == $past(bit_in)) && (word[WORD_W-1:1] == $past(word[WORD_W-2:0])));
endmodule

// File: rtl/srl_latch_bank.sv
module srl_latch_bank
  import srl_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [WORD_W-1:0] word,
  output logic [RDIV_W-1:0] r_div,
  output logic [NINT_W-1:0] n_int,
  output logic [FRAC_W-1:0] frac,
  output logic [MOD_W-1:0]  mod_active,
  output logic [WORD_W-1:0] ctrl_word,
  output logic [WORD_W-1:0] spur_word,
  output logic [MUX_W-1:0]  mux_sel,
  output logic [N_REGS-1:0] upd_stb,
  output logic              mod_stb
);
  logic [MOD_W-1:0] mod_stage;
  reg_addr_e        addr;

  assign addr = reg_addr_e'(word[ADDR_W-1:0]);

  always_ff @(posedge clk) begin
    if (rst) begin
      r_div      <= '0;
      n_int      <= '0;
      frac       <= '0;
      mod_stage  <= '0;
      mod_active <= '0;
      ctrl_word  <= '0;
      spur_word  <= '0;
      mux_sel    <= MUX_HIZ;
      upd_stb    <= '0;
      mod_stb    <= 1'b0;
    end else begin
      upd_stb <= '0;
      mod_stb <= 1'b0;
      if (load) begin
        upd_stb[addr] <= 1'b1;
        unique case (addr)
          ADR_FB: begin
            n_int      <= word[NINT_LSB +: NINT_W];
            frac       <= word[FRAC_LSB +: FRAC_W];
            mod_active <= mod_stage;
            mod_stb    <= (mod_stage != mod_active);
          end
          ADR_REF: begin
            r_div     <= word[RDIV_LSB +: RDIV_W];
            mod_stage <= word[MOD_LSB +: MOD_W];
          end
          ADR_CTRL: begin
            ctrl_word <= word;
            mux_sel   <= word[MUX_LSB +: MUX_W];
          end
          ADR_SPUR: spur_word <= word;
          default: ;
        endcase
      end
    end
  end

  // R9: at most one holding register is written per cycle
  a_r9_strobe_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(upd_stb));

  // R8: the active modulus moves only together with a feedback write
  a_r8_mod_only_on_fb: assert property (@(posedge clk) disable iff (rst)
    !$stable(mod_active) |-> upd_stb[ADR_FB]);

  // R8: the modulus strobe marks an actual change
  a_r8_mod_stb_change: assert property (@(posedge clk) disable iff (rst)
    mod_stb |-> upd_stb[ADR_FB] && !$stable(mod_active));

  // R4: a reference write leaves the active modulus alone
  a_r4_ref_keeps_mod: assert property (@(posedge clk) disable iff (rst)
    upd_stb[ADR_REF] |-> $stable(mod_active));

  // R7: the control word is untouched unless the control register is written
  a_r7_ctrl_isolated: assert property (@(posedge clk) disable iff (rst)
    !upd_stb[ADR_CTRL] |-> $stable(ctrl_word) && $stable(mux_sel));
endmodule

// File: rtl/serial_reg_loader.sv
module serial_reg_loader
  import srl_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_clk,
  input  logic              ser_data,
  input  logic              ser_le,
  output logic [RDIV_W-1:0] r_div,
  output logic [NINT_W-1:0] n_int,
  output logic [FRAC_W-1:0] frac,
  output logic [MOD_W-1:0]  mod_active,
  output logic [WORD_W-1:0] ctrl_word,
  output logic [WORD_W-1:0] spur_word,
  output logic [MUX_W-1:0]  mux_sel,
  output logic [N_REGS-1:0] upd_stb,
  output logic              mod_stb
);
  logic [2:0]        pins_s;
  logic [1:0]        rises;
  logic [WORD_W-1:0] shift_word;

  srl_sync #(.W(3), .STAGES(SYNC_N)) i_sync (
    .clk (clk),
    .rst (rst),
    .d   ({ser_le, ser_data, ser_clk}),
    .q   (pins_s)
  );

  srl_edge #(.W(2)) i_edge (
    .clk  (clk),
    .rst  (rst),
    .sig  ({pins_s[2], pins_s[0]}),
    .rise (rises)
  );

  srl_shifter i_shift (
    .clk      (clk),
    .rst      (rst),
    .shift_en (rises[0]),
    .bit_in   (pins_s[1]),
    .word     (shift_word)
  );

  srl_latch_bank i_bank (
    .clk        (clk),
    .rst        (rst),
    .load       (rises[1]),
    .word       (shift_word),
    .r_div      (r_div),
    .n_int      (n_int),
    .frac       (frac),
    .mod_active (mod_active),
    .ctrl_word  (ctrl_word),
    .spur_word  (spur_word),
    .mux_sel    (mux_sel),
    .upd_stb    (upd_stb),
    .mod_stb    (mod_stb)
  );

  // R10: a write strobe only follows a synchronized load edge
  a_r10_no_load_no_write: assert property (@(posedge clk) disable iff (rst)
    !$past(rises[1]) |-> upd_stb == '0);
endmodule

// File: tb/test_serial_reg_loader.sv
module test_serial_reg_loader;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ser_clk = 1'b0, ser_data = 1'b0, ser_le = 1'b0;
  logic [3:0]  r_div;
  logic [8:0]  n_int;
  logic [11:0] frac, mod_active;
  logic [23:0] ctrl_word, spur_word;
  logic [2:0]  mux_sel;
  logic [3:0]  upd_stb;
  logic        mod_stb;

  int tests = 0, fails = 0;
  int stb_cnt [4];
  int mod_cnt = 0;

  logic [23:0] m_shift = '0;
  logic [3:0]  e_r = '0;
  logic [8:0]  e_n = '0;
  logic [11:0] e_frac = '0, e_stage = '0, e_mod = '0;
  logic [23:0] e_ctrl = '0, e_spur = '0;
  logic [2:0]  e_mux = '0;

  always #2 clk = ~clk;

  serial_reg_loader i_serial_reg_loader (
    .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_data(ser_data), .ser_le(ser_le),
    .r_div(r_div), .n_int(n_int), .frac(frac), .mod_active(mod_active),
    .ctrl_word(ctrl_word), .spur_word(spur_word), .mux_sel(mux_sel),
    .upd_stb(upd_stb), .mod_stb(mod_stb)
  );

  always @(negedge clk) begin
    for (int i = 0; i < 4; i++) if (upd_stb[i]) stb_cnt[i]++;
    if (mod_stb) mod_cnt++;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_outputs(input string req);
    check({req, " r_div"}, 32'(r_div), 32'(e_r));
    check({req, " n_int"}, 32'(n_int), 32'(e_n));
    check({req, " frac"}, 32'(frac), 32'(e_frac));
    check({req, " mod_active"}, 32'(mod_active), 32'(e_mod));
    check({req, " ctrl_word"}, 32'(ctrl_word), 32'(e_ctrl));
    check({req, " spur_word"}, 32'(spur_word), 32'(e_spur));
    check({req, " mux_sel"}, 32'(mux_sel), 32'(e_mux));
  endtask

  task automatic send_bits(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      ser_data = v[i];
      repeat (3) @(negedge clk);
      ser_clk = 1'b1;
      repeat (4) @(negedge clk);
      ser_clk = 1'b0;
      repeat (3) @(negedge clk);
      m_shift = {m_shift[22:0], v[i]};
    end
  endtask

  task automatic load(input string req);
    logic [1:0] a;
    logic       exp_mod;
    for (int i = 0; i < 4; i++) stb_cnt[i] = 0;
    mod_cnt = 0;
    exp_mod = 1'b0;
    a = m_shift[1:0];
    case (a)
      2'd0: begin
        e_n = m_shift[22:14]; e_frac = m_shift[13:2];
        exp_mod = (e_stage != e_mod); e_mod = e_stage;
      end
      2'd1: begin e_r = m_shift[17:14]; e_stage = m_shift[13:2]; end
      2'd2: begin e_ctrl = m_shift; e_mux = m_shift[4:2]; end
      default: e_spur = m_shift;
    endcase
    ser_le = 1'b1;
    repeat (5) @(negedge clk);
    ser_le = 1'b0;
    repeat (8) @(negedge clk);
    check_outputs(req);
    for (int i = 0; i < 4; i++)
      check({req, " R9 strobe"}, 32'(stb_cnt[i]), (i == int'(a)) ? 32'd1 : 32'd0);
    check({req, " R8 mod_stb"}, 32'(mod_cnt), 32'(exp_mod));
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [23:0] w;
    int seed;
    seed = 32'h5eed_1234;
    void'($urandom(seed));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    // R1 reset state
    check_outputs("R1");
    check("R1 upd_stb", 32'(upd_stb), 0);
    check("R1 mod_stb", 32'(mod_stb), 0);

    // R4 stage modulus, R3 then apply
    send_bits({8'd0, 2'd0, 4'hA, 12'h123, 2'd1}, 24); load("R4 ref");
    send_bits({1'b0, 9'h1A5, 12'hABC, 2'd0}, 24);    load("R3 fb R8 apply");
    // R8 repeated feedback write with no change: no modulus strobe
    send_bits({1'b0, 9'h055, 12'h321, 2'd0}, 24);    load("R8 same mod");
    // R5 control, R6 spur
    send_bits({19'h4_1234, 3'b110, 2'd2}, 24);       load("R5 ctrl");
    send_bits(24'hC3_5A5F, 24);                      load("R6 spur");
    // R2 long burst: only the last 24 bits count
    send_bits(32'hFFFF_FFFF, 6);
    send_bits({8'd0, 2'd0, 4'h5, 12'hFED, 2'd1}, 24); load("R2 long");
    // R2 short burst: older bits remain in the word
    send_bits({6'd0, 2'd3}, 8);                      load("R2 short");
    // R10 shifting without load changes nothing
    send_bits(24'h00_0002, 24);
    check_outputs("R10");
    // R7 staged modulus hidden across other writes, then applied
    send_bits({8'd0, 2'd0, 4'h3, 12'h777, 2'd1}, 24); load("R7 ref");
    send_bits({19'h0, 3'b011, 2'd2}, 24);            load("R7 ctrl");
    send_bits({1'b1, 9'h0FF, 12'h000, 2'd0}, 24);    load("R8 apply2");

    for (int k = 0; k < 60; k++) begin
      w = 24'($urandom);
      if (($urandom % 5) == 0) send_bits($urandom, 1 + ($urandom % 8));
      send_bits(32'(w), 24);
      load("R7 random");
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule